// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block takes the three-wire programming port of a two-channel frequency synthesizer and turns it into decoded configuration fields. A host drives a serial data pin, a serial bit clock and a load strobe. The block samples all three pins in its own system clock domain. Each rising edge of the bit clock appends one data bit to a 22-bit frame register. A rising edge of the load strobe copies the frame payload into one of four holding words. The four words are the reference word and the counter word of each of the two channels.

The last two bits of a frame form a destination code. A reference word carries the reference divider ratio, the phase detector sense, the charge-pump current select, the charge-pump three-state control, the lock-detect select and the test-monitor select. A counter word carries the main and swallow counter ratios, the prescaler modulus select and the power-down control. The divider and analog logic that consume these fields sit outside this block.

All output ports are two-entry packed arrays. Index 0 is channel 1 and index 1 is channel 2.

Top module: `sps_loader`

## Requirements
- R1: After reset, every holding word is zero except the two power-down bits, which read 1.
- R2: Each rising edge of `ser_clk` shifts the level of `ser_data` into the frame with the most significant bit first. The frame is the last 22 bits shifted, and any earlier bits are dropped.
- R3: The last bit shifted (L) and the bit before it (P) form the code {L,P}. Code 00 loads the channel 2 reference word, 10 loads the channel 1 reference word, 01 loads the channel 2 counter word and 11 loads the channel 1 counter word. The other three words keep their values.
- R4: In a reference frame, the bits in shift order are: monitor select, lock-detect select, three-state, charge-pump high current, positive phase sense, then the 15-bit reference ratio MSB first, then the two code bits.
- R5: In a counter frame, the bits in shift order are: power-down, prescaler high modulus, the 11-bit main ratio MSB first, the 7-bit swallow ratio MSB first, then the two code bits.
- R6: Shifting bits without a rising edge of `ser_le` leaves every output unchanged.
- R7: Frames are accepted and latched for a channel whose power-down bit is set, including a frame that keeps it powered down.
- R8: A load completes correctly when `ser_clk` stays high across the `ser_le` rising edge. The later fall of `ser_clk` changes nothing.
- R9: When a `ser_clk` rise and a `ser_le` rise are seen in the same cycle, the load takes the frame as it was before that bit. The bit still enters the frame.
- R10: Holding `ser_le` high causes a single load. Bits shifted while it stays high are latched only at its next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load strobe, asynchronous |
| ref_ratio | output | 2x15 | Reference divider ratio per channel |
| phase_pos | output | 2 | Positive phase detector sense |
| cp_high | output | 2 | Charge-pump high-current select |
| cp_tristate | output | 2 | Charge-pump output three-state |
| ld_sel | output | 2 | Lock-detect select bit |
| fout_sel | output | 2 | Test-monitor select bit |
| main_div | output | 2x11 | Main counter ratio per channel |
| swallow | output | 2x7 | Swallow counter ratio per channel |
| presc_hi | output | 2 | Prescaler high modulus select |
| power_down | output | 2 | Channel power-down |

## Verification
A bit-clock rise and a load-strobe rise can be seen in the same sampled cycle. When that happens, the load must take the frame as it stood before that bit, and the bit must still enter the frame. The bench provokes this by raising both pins on the same clock edge. It first checks that the words show the earlier frame. It then shifts 21 more bits and loads again. The second load is judged correct only if the coincident bit became the top bit of the new frame.

// File: rtl/sps_pkg.sv
package sps_pkg;
    localparam int NCH     = 2;
    localparam int R_W     = 15;
    localparam int A_W     = 7;
    localparam int B_W     = 11;
    localparam int CTL_W   = 2;
    localparam int PAY_W   = 5 + R_W;
    localparam int FRAME_W = PAY_W + CTL_W;

    typedef struct packed {
        logic           fout;
        logic           ld;
        logic           ts;
        logic           cp_hi;
        logic           pos;
        logic [R_W-1:0] ratio;
    } ref_word_t;

    typedef struct packed {
        logic           pd;
        logic           presc;
        logic [B_W-1:0] b;
        logic [A_W-1:0] a;
    } cnt_word_t;

    localparam cnt_word_t CNT_RST = '{pd: 1'b1, presc: 1'b0, b: '0, a: '0};

    function automatic logic [1:0] ref_code(input int ch);
        return (ch == 0) ? 2'b10 : 2'b00;
    endfunction

    function automatic logic [1:0] cnt_code(input int ch);
        return (ch == 0) ? 2'b11 : 2'b01;
    endfunction
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], pin};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level = s_q.chain[STAGES-1];
endmodule

// File: rtl/sps_rise.sv
module sps_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic lvl;
    logic prev_d, prev_q;

    sps_sync #(.STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin),
        .level(lvl)
    );

    always_comb prev_d = lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/sps_shifter.sv
module sps_shifter import sps_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame
);
    logic [FRAME_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_en) sr_d = {sr_q[FRAME_W-2:0], bit_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign frame = sr_q;
endmodule

// File: rtl/sps_route.sv
module sps_route import sps_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output ref_word_t          rw [NCH],
    output cnt_word_t          cw [NCH]
);
    typedef struct packed {
        ref_word_t [NCH-1:0] rw;
        cnt_word_t [NCH-1:0] cw;
    } hold_t;

    hold_t      h_d, h_q;
    logic [1:0] dst;

    // The last bit shifted is the high bit of the code.
    assign dst = {frame[0], frame[1]};

    always_comb begin
        h_d = h_q;
        if (load) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (dst == ref_code(ch)) h_d.rw[ch] = ref_word_t'(frame[FRAME_W-1:CTL_W]);
                if (dst == cnt_code(ch)) h_d.cw[ch] = cnt_word_t'(frame[FRAME_W-1:CTL_W]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int ch = 0; ch < NCH; ch++) begin
                h_q.rw[ch] <= '0;
                h_q.cw[ch] <= CNT_RST;
            end
        end else begin
            h_q <= h_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign rw[g] = h_q.rw[g];
        assign cw[g] = h_q.cw[g];
    end
endmodule

// File: rtl/sps_loader.sv
module sps_loader import sps_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_data,
    input  logic                     ser_le,
    output logic [NCH-1:0][R_W-1:0]  ref_ratio,
    output logic [NCH-1:0]           phase_pos,
    output logic [NCH-1:0]           cp_high,
    output logic [NCH-1:0]           cp_tristate,
    output logic [NCH-1:0]           ld_sel,
    output logic [NCH-1:0]           fout_sel,
    output logic [NCH-1:0][B_W-1:0]  main_div,
    output logic [NCH-1:0][A_W-1:0]  swallow,
    output logic [NCH-1:0]           presc_hi,
    output logic [NCH-1:0]           power_down
);
    logic               sclk_rise;
    logic               sle_rise;
    logic               sdata_lvl;
    logic [FRAME_W-1:0] frame_q;
    ref_word_t          rw [NCH];
    cnt_word_t          cw [NCH];

    sps_rise #(.STAGES(SYNC_STAGES)) u_clk_edge (
        .clk(clk), .rst_n(rst_n), .pin(ser_clk), .rise(sclk_rise)
    );

    sps_rise #(.STAGES(SYNC_STAGES)) u_le_edge (
        .clk(clk), .rst_n(rst_n), .pin(ser_le), .rise(sle_rise)
    );

    sps_sync #(.STAGES(SYNC_STAGES)) u_data_sync (
        .clk(clk), .rst_n(rst_n), .pin(ser_data), .level(sdata_lvl)
    );

    sps_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise),
        .bit_in(sdata_lvl), .frame(frame_q)
    );

    // The load reads frame_q before a coincident shift takes effect.
    sps_route u_route (
        .clk(clk), .rst_n(rst_n), .load(sle_rise),
        .frame(frame_q), .rw(rw), .cw(cw)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign ref_ratio[g]   = rw[g].ratio;
        assign phase_pos[g]   = rw[g].pos;
        assign cp_high[g]     = rw[g].cp_hi;
        assign cp_tristate[g] = rw[g].ts;
        assign ld_sel[g]      = rw[g].ld;
        assign fout_sel[g]    = rw[g].fout;
        assign main_div[g]    = cw[g].b;
        assign swallow[g]     = cw[g].a;
        assign presc_hi[g]    = cw[g].presc;
        assign power_down[g]  = cw[g].pd;
    end
endmodule

// File: rtl/sps_loader_chk.sv
module sps_loader_chk import sps_pkg::*; (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sclk_rise,
    input logic                    sle_rise,
    input logic                    sdata_lvl,
    input logic [FRAME_W-1:0]      frame_q,
    input logic [NCH-1:0][R_W-1:0] ref_ratio,
    input logic [NCH-1:0]          fout_sel,
    input logic [NCH-1:0]          phase_pos,
    input logic [NCH-1:0][B_W-1:0] main_div,
    input logic [NCH-1:0][A_W-1:0] swallow,
    input logic [NCH-1:0]          presc_hi,
    input logic [NCH-1:0]          power_down
);
    assert_hold_without_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sle_rise |=> ($stable(ref_ratio) && $stable(fout_sel) && $stable(phase_pos) &&
                       $stable(main_div) && $stable(swallow) && $stable(presc_hi) &&
                       $stable(power_down)));

    assert_ref_load_spares_counters_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sle_rise && !frame_q[1]) |=> ($stable(main_div) && $stable(swallow) &&
                                       $stable(presc_hi) && $stable(power_down)));

    assert_cnt1_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sle_rise && frame_q[0] && frame_q[1]) |=>
        (main_div[0] == $past(frame_q[CTL_W+A_W +: B_W]) &&
         swallow[0] == $past(frame_q[CTL_W +: A_W]) &&
         power_down[0] == $past(frame_q[FRAME_W-1])));

    assert_ref2_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sle_rise && !frame_q[0] && !frame_q[1]) |=>
        (ref_ratio[1] == $past(frame_q[CTL_W +: R_W]) &&
         fout_sel[1] == $past(frame_q[FRAME_W-1])));

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> (frame_q[0] == $past(sdata_lvl) &&
                       frame_q[FRAME_W-1:1] == $past(frame_q[FRAME_W-2:0])));
endmodule

bind sps_loader sps_loader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sle_rise(sle_rise),
    .sdata_lvl(sdata_lvl), .frame_q(frame_q), .ref_ratio(ref_ratio),
    .fout_sel(fout_sel), .phase_pos(phase_pos), .main_div(main_div),
    .swallow(swallow), .presc_hi(presc_hi), .power_down(power_down)
);

// File: tb/sps_loader_test.sv
module sps_loader_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [1:0][14:0] ref_ratio;
    logic [1:0] phase_pos, cp_high, cp_tristate, ld_sel, fout_sel, presc_hi, power_down;
    logic [1:0][10:0] main_div;
    logic [1:0][6:0]  swallow;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [19:0] e_ref [2];
    logic [19:0] e_cnt [2];

    always #2 clk = ~clk;

    sps_loader uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .phase_pos(phase_pos), .cp_high(cp_high),
        .cp_tristate(cp_tristate), .ld_sel(ld_sel), .fout_sel(fout_sel),
        .main_div(main_div), .swallow(swallow), .presc_hi(presc_hi), .power_down(power_down)
    );

    function automatic void model_load(input logic [21:0] f);
        case ({f[0], f[1]})
            2'b00: e_ref[1] = f[21:2];
            2'b10: e_ref[0] = f[21:2];
            2'b01: e_cnt[1] = f[21:2];
            default: e_cnt[0] = f[21:2];
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [19:0] act, input logic [19:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < 2; c++) begin
            check(tag, c == 0 ? "ref ch1" : "ref ch2",
                  {fout_sel[c], ld_sel[c], cp_tristate[c], cp_high[c], phase_pos[c], ref_ratio[c]}, e_ref[c]);
            check(tag, c == 0 ? "cnt ch1" : "cnt ch2",
                  {power_down[c], presc_hi[c], main_div[c], swallow[c]}, e_cnt[c]);
        end
    endtask

    task automatic put_bit(input logic b, input bit hold_high);
        @(negedge clk) ser_data = b;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        if (!hold_high) ser_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic shift_frame(input logic [21:0] f, input bit hold_last);
        for (int i = 21; i >= 0; i--) put_bit(f[i], hold_last && (i == 0));
    endtask

    task automatic pulse_le();
        @(negedge clk) ser_le = 1'b1;
        repeat (5) @(negedge clk);
        ser_le = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic load_frame(input logic [21:0] f, input string tag);
        shift_frame(f, 1'b0);
        pulse_le();
        model_load(f);
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [21:0] f, g;
        int unsigned seed;
        seed = $urandom(32'd20517);
        e_ref[0] = '0; e_ref[1] = '0;
        e_cnt[0] = 20'h80000; e_cnt[1] = 20'h80000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1");

        // R6: bits shifted but no load strobe
        shift_frame(22'h3FFFFF, 1'b0);
        repeat (8) @(negedge clk);
        check_all("R6");

        // R4: reference words, codes 10 (ch1) and 00 (ch2)
        load_frame({1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 15'h5A5A, 1'b0, 1'b1}, "R4");
        load_frame({1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 15'h7FFF, 1'b0, 1'b0}, "R4");

        // R5: counter words, codes 11 (ch1) and 01 (ch2)
        load_frame({1'b0, 1'b1, 11'h7FF, 7'h40, 1'b1, 1'b1}, "R5");
        load_frame({1'b0, 1'b0, 11'h003, 7'h3F, 1'b1, 1'b0}, "R5");

        // R7: channel 2 powered down, then further loads for it
        load_frame({1'b1, 1'b1, 11'h123, 7'h15, 1'b1, 1'b0}, "R7");
        load_frame({1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 15'h0003, 1'b0, 1'b0}, "R7");
        load_frame({1'b1, 1'b0, 11'h456, 7'h2A, 1'b1, 1'b0}, "R7");

        // R8: ser_clk left high across the load
        f = {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 15'h1234, 1'b0, 1'b1};
        shift_frame(f, 1'b1);
        pulse_le();
        model_load(f);
        check_all("R8");
        @(negedge clk) ser_clk = 1'b0;
        repeat (8) @(negedge clk);
        check_all("R8");

        // R2: three extra leading bits fall out of the frame
        put_bit(1'b1, 1'b0); put_bit(1'b0, 1'b0); put_bit(1'b1, 1'b0);
        load_frame({1'b0, 1'b0, 11'h2AA, 7'h55, 1'b1, 1'b1}, "R2");

        // R10: strobe held high loads once
        f = {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 15'h6ABC, 1'b0, 1'b0};
        g = {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 15'h0101, 1'b0, 1'b0};
        shift_frame(f, 1'b0);
        @(negedge clk) ser_le = 1'b1;
        repeat (6) @(negedge clk);
        model_load(f);
        check_all("R10");
        shift_frame(g, 1'b0);
        repeat (6) @(negedge clk);
        check_all("R10");
        ser_le = 1'b0;
        repeat (6) @(negedge clk);
        pulse_le();
        model_load(g);
        check_all("R10");

        // R9: coincident bit-clock and strobe edges
        f = {1'b1, 1'b0, 11'h0F0, 7'h0F, 1'b1, 1'b1};
        g = {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 15'h2222, 1'b0, 1'b1};
        shift_frame(f, 1'b0);
        @(negedge clk) ser_data = g[21];
        repeat (4) @(negedge clk);
        ser_clk = 1'b1; ser_le = 1'b1;
        repeat (5) @(negedge clk);
        ser_clk = 1'b0; ser_le = 1'b0;
        repeat (6) @(negedge clk);
        model_load(f);
        check_all("R9");
        for (int i = 20; i >= 0; i--) put_bit(g[i], 1'b0);
        pulse_le();
        model_load(g);
        check_all("R9");

        // R3: random frames across all four destinations
        for (int k = 0; k < 40; k++) begin
            f = 22'($urandom());
            load_frame(f, "R3");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule